// File: doc/BRIEF.md
# DRAM RAS/CAS Access Sequencer

This block converts plain host reads and writes into multiplexed-address cycles for an asynchronous DRAM. The host presents a flat word address, a direction, a burst length and the write data for every beat, and holds the request until `done` pulses. The sequencer places the row half of the address on a shared address bus, drops RAS, then swaps in the column half and drops CAS. Each of these steps lasts a number of clock cycles fixed by parameters. Read data comes back one beat at a time on `rd_data` with a `rd_valid` strobe.

A burst longer than one beat runs in page mode. RAS falls once, and then a train of CAS pulses walks through consecutive columns of the same row. A write keeps WE low from before the first CAS fall until the cycle ends. RAS rises while CAS is still low, which writes the row back, and CAS and WE are released after that. The data pin's output enable is active only during write column phases. A refresh grant input holds the sequencer in idle so that an external refresh engine can own the pins. An access that has already started always runs to completion.

Top module: `dram_rc_seq`

## Requirements
- R1: During reset and right after it, `dram_ras_n`, `dram_cas_n` and `dram_we_n` are 1, and `dram_dq_oe`, `done` and `rd_valid` are 0.
- R2: When `dram_ras_n` falls, `dram_addr` carries the row, which is the upper ROW_W bits of `req_addr`. When `dram_cas_n` falls, it carries the column, which is the lower COL_W bits.
- R3: The first CAS fall comes exactly T_RCD+1 cycles after the RAS fall. Every CAS low pulse that ends while RAS is low lasts exactly T_CAS cycles.
- R4: Write ordering. WE is already low in the cycle before each CAS fall. After the last beat, RAS rises while CAS is still low. One cycle later, CAS and WE rise together.
- R5: `dram_dq_oe` is 1 only while WE is low, and it is never 1 during a read. At every write CAS fall, `dram_dq_o` equals beat k's word, `req_wdata[k*DW +: DW]`.
- R6: For each read beat, `rd_valid` is 1 for one cycle. `rd_data` holds the value that `dram_dq_i` carried in the last cycle of that beat's CAS pulse.
- R7: A request with `req_len` = L gives one RAS fall and L+1 CAS pulses. Beat k uses column (col + k) mod 2^COL_W in the same row.
- R8: `done` is 1 for exactly one cycle per request. That cycle and the following T_RP-1 cycles keep RAS, CAS and WE high.
- R9: While `ref_grant` is 1 in idle, no access starts and RAS stays high. If the grant rises during an access, the access still completes.
- R10: Request fields are captured in the cycle the request is accepted. Changes to `req_addr`, `req_write` or `req_wdata` after that have no effect on the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; held until done |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Word address, row in the upper bits |
| req_len | input | BEAT_W | Beats minus one |
| req_wdata | input | MAX_BEATS*DW | Write data, beat k at bits k*DW |
| ref_grant | input | 1 | Refresh owns the DRAM; blocks new accesses |
| rd_data | output | DW | Read beat data |
| rd_valid | output | 1 | rd_data valid strobe |
| done | output | 1 | Access completed pulse |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_dq_o | output | DW | Write data to the DRAM |
| dram_dq_oe | output | 1 | Drive enable for the data pin |
| dram_dq_i | input | DW | Read data from the DRAM |

## Verification
The bench uses a behavioural DRAM that latches the row and column on the strobe edges. It drives data only while CAS is low on a read. Single-beat and four-beat accesses, in both directions, are mixed at random addresses, and some bursts start near the end of a row so that the column wrap separates correct column stepping from carries into the row. Directed cases hold the refresh grant before a request and raise it during an access, which distinguishes blocking at idle from aborting. Another directed case changes every request field after RAS falls, which shows whether the fields were captured at acceptance or read live.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RSET = 3'd1,
    ST_RACT = 3'd2,
    ST_CSET = 3'd3,
    ST_CACT = 3'd4,
    ST_WBCK = 3'd5,
    ST_PRE  = 3'd6
  } seq_state_e;

  typedef struct packed {
    logic ras_n;
    logic cas_n;
    logic we_n;
    logic oe;
    logic col_sel;
  } pin_ctl_t;

  // Pin levels for each sequencer step
  function automatic pin_ctl_t step_pins(seq_state_e st, logic wr);
    pin_ctl_t p;
    p = '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, oe: 1'b0, col_sel: 1'b0};
    case (st)
      ST_RACT: p.ras_n = 1'b0;
      ST_CSET: begin
        p.ras_n   = 1'b0;
        p.we_n    = ~wr;
        p.oe      = wr;
        p.col_sel = 1'b1;
      end
      ST_CACT: begin
        p.ras_n   = 1'b0;
        p.cas_n   = 1'b0;
        p.we_n    = ~wr;
        p.oe      = wr;
        p.col_sel = 1'b1;
      end
      ST_WBCK: begin
        p.cas_n   = 1'b0;
        p.we_n    = 1'b0;
        p.oe      = 1'b1;
        p.col_sel = 1'b1;
      end
      default: ;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/dram_step_timer.sv
module dram_step_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/dram_addr_mux.sv
module dram_addr_mux #(
  parameter int ROW_W  = 6,
  parameter int COL_W  = 6,
  parameter int BEAT_W = 2,
  localparam int AW    = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic [ROW_W-1:0]  row,
  input  logic [COL_W-1:0]  col_base,
  input  logic [BEAT_W-1:0] beat,
  input  logic              col_sel,
  output logic [AW-1:0]     addr
);

  logic [COL_W-1:0] col_eff;
  logic [AW-1:0]    row_pad;
  logic [AW-1:0]    col_pad;

  // column steps within the row and wraps at its end
  assign col_eff = col_base + COL_W'(beat);

  generate
    if (ROW_W < AW) begin : g_row_pad
      assign row_pad = {{(AW-ROW_W){1'b0}}, row};
    end else begin : g_row_full
      assign row_pad = row;
    end
    if (COL_W < AW) begin : g_col_pad
      assign col_pad = {{(AW-COL_W){1'b0}}, col_eff};
    end else begin : g_col_full
      assign col_pad = col_eff;
    end
  endgenerate

  assign addr = col_sel ? col_pad : row_pad;

endmodule

// File: rtl/dram_beat_data.sv
module dram_beat_data #(
  parameter int DW        = 1,
  parameter int MAX_BEATS = 4,
  parameter int BEAT_W    = 2
) (
  input  logic [MAX_BEATS*DW-1:0] wdata_vec,
  input  logic [BEAT_W-1:0]       beat,
  output logic [DW-1:0]           word
);

  logic [DW-1:0] words [MAX_BEATS];

  generate
    for (genvar g = 0; g < MAX_BEATS; g++) begin : g_slice
      assign words[g] = wdata_vec[g*DW +: DW];
    end
  endgenerate

  assign word = words[beat];

endmodule

// File: rtl/dram_seq_fsm.sv
module dram_seq_fsm
  import dram_seq_pkg::*;
#(
  parameter int BEAT_W = 2,
  parameter int CW     = 4,
  parameter int T_RCD  = 2,
  parameter int T_CAS  = 2,
  parameter int T_RP   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              wr,
  input  logic [BEAT_W-1:0] len,
  input  logic              expired,
  output seq_state_e        state_q,
  output seq_state_e        state_d,
  output logic [BEAT_W-1:0] beat_q,
  output logic [BEAT_W-1:0] beat_d,
  output logic              tmr_load,
  output logic [CW-1:0]     tmr_val
);

  logic beat_en;

  always_comb begin
    state_d  = state_q;
    beat_d   = beat_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (state_q)
      ST_IDLE: if (start) begin
        state_d = ST_RSET;
        beat_d  = '0;
      end
      ST_RSET: begin
        state_d  = ST_RACT;
        tmr_load = 1'b1;
        tmr_val  = CW'(T_RCD - 1);
      end
      ST_RACT: if (expired) state_d = ST_CSET;
      ST_CSET: begin
        state_d  = ST_CACT;
        tmr_load = 1'b1;
        tmr_val  = CW'(T_CAS - 1);
      end
      ST_CACT: if (expired) begin
        if (beat_q != len) begin
          state_d = ST_CSET;
          beat_d  = beat_q + 1'b1;
        end else if (wr) begin
          state_d = ST_WBCK;
        end else begin
          state_d  = ST_PRE;
          tmr_load = 1'b1;
          tmr_val  = CW'(T_RP - 1);
        end
      end
      ST_WBCK: begin
        state_d  = ST_PRE;
        tmr_load = 1'b1;
        tmr_val  = CW'(T_RP - 1);
      end
      ST_PRE: if (expired) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign beat_en = (beat_d != beat_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       beat_q <= '0;
    else if (beat_en) beat_q <= beat_d;
  end

endmodule

// File: rtl/dram_rc_seq.sv
module dram_rc_seq
  import dram_seq_pkg::*;
#(
  parameter int ROW_W     = 6,
  parameter int COL_W     = 6,
  parameter int DW        = 1,
  parameter int MAX_BEATS = 4,
  parameter int T_RCD     = 2,
  parameter int T_CAS     = 2,
  parameter int T_RP      = 2,
  localparam int AW       = (ROW_W > COL_W) ? ROW_W : COL_W,
  localparam int BEAT_W   = (MAX_BEATS > 1) ? $clog2(MAX_BEATS) : 1,
  localparam int TMAX     = (T_RCD > T_CAS) ? ((T_RCD > T_RP) ? T_RCD : T_RP)
                                            : ((T_CAS > T_RP) ? T_CAS : T_RP),
  localparam int CW       = $clog2(TMAX + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic                    req_write,
  input  logic [ROW_W+COL_W-1:0]  req_addr,
  input  logic [BEAT_W-1:0]       req_len,
  input  logic [MAX_BEATS*DW-1:0] req_wdata,
  input  logic                    ref_grant,
  output logic [DW-1:0]           rd_data,
  output logic                    rd_valid,
  output logic                    done,
  output logic [AW-1:0]           dram_addr,
  output logic                    dram_ras_n,
  output logic                    dram_cas_n,
  output logic                    dram_we_n,
  output logic [DW-1:0]           dram_dq_o,
  output logic                    dram_dq_oe,
  input  logic [DW-1:0]           dram_dq_i
);

  seq_state_e               state_q, state_d;
  logic [BEAT_W-1:0]        beat_q, beat_d;
  logic                     tmr_load, expired;
  logic [CW-1:0]            tmr_val;
  logic                     start, cap_en;

  logic [ROW_W-1:0]         row_q, row_d;
  logic [COL_W-1:0]         col_q, col_d;
  logic                     wr_q, wr_d;
  logic [BEAT_W-1:0]        len_q, len_d;
  logic [MAX_BEATS*DW-1:0]  wdat_q, wdat_d;

  pin_ctl_t                 pins_d;
  logic [AW-1:0]            addr_d;
  logic [DW-1:0]            beat_word;
  logic                     rd_cap, done_d;

  assign start  = req_valid && !ref_grant;
  assign cap_en = (state_q == ST_IDLE) && start;

  // request capture
  always_comb begin
    row_d  = cap_en ? req_addr[ROW_W+COL_W-1:COL_W] : row_q;
    col_d  = cap_en ? req_addr[COL_W-1:0]           : col_q;
    wr_d   = cap_en ? req_write                     : wr_q;
    len_d  = cap_en ? req_len                       : len_q;
    wdat_d = cap_en ? req_wdata                     : wdat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q  <= '0;
      col_q  <= '0;
      wr_q   <= 1'b0;
      len_q  <= '0;
      wdat_q <= '0;
    end else if (cap_en) begin
      row_q  <= row_d;
      col_q  <= col_d;
      wr_q   <= wr_d;
      len_q  <= len_d;
      wdat_q <= wdat_d;
    end
  end

  dram_seq_fsm #(
    .BEAT_W (BEAT_W),
    .CW     (CW),
    .T_RCD  (T_RCD),
    .T_CAS  (T_CAS),
    .T_RP   (T_RP)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .wr       (wr_q),
    .len      (len_q),
    .expired  (expired),
    .state_q  (state_q),
    .state_d  (state_d),
    .beat_q   (beat_q),
    .beat_d   (beat_d),
    .tmr_load (tmr_load),
    .tmr_val  (tmr_val)
  );

  dram_step_timer #(.CW(CW)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (expired)
  );

  dram_addr_mux #(
    .ROW_W  (ROW_W),
    .COL_W  (COL_W),
    .BEAT_W (BEAT_W)
  ) u_amux (
    .row      (row_d),
    .col_base (col_d),
    .beat     (beat_d),
    .col_sel  (pins_d.col_sel),
    .addr     (addr_d)
  );

  dram_beat_data #(
    .DW        (DW),
    .MAX_BEATS (MAX_BEATS),
    .BEAT_W    (BEAT_W)
  ) u_bdat (
    .wdata_vec (wdat_d),
    .beat      (beat_d),
    .word      (beat_word)
  );

  // pin levels follow the next step and are registered
  assign pins_d = step_pins(state_d, wr_d);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dram_ras_n <= 1'b1;
      dram_cas_n <= 1'b1;
      dram_we_n  <= 1'b1;
      dram_dq_oe <= 1'b0;
      dram_addr  <= '0;
      dram_dq_o  <= '0;
    end else begin
      dram_ras_n <= pins_d.ras_n;
      dram_cas_n <= pins_d.cas_n;
      dram_we_n  <= pins_d.we_n;
      dram_dq_oe <= pins_d.oe;
      dram_addr  <= addr_d;
      dram_dq_o  <= pins_d.oe ? beat_word : '0;
    end
  end

  // read beat capture in the last CAS cycle
  assign rd_cap = (state_q == ST_CACT) && expired && !wr_q;
  assign done_d = (state_d == ST_PRE) && (state_q != ST_PRE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_data <= '0;
    else if (rd_cap) rd_data <= dram_dq_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      done     <= 1'b0;
    end else begin
      rd_valid <= rd_cap;
      done     <= done_d;
    end
  end

endmodule

// File: rtl/dram_rc_seq_chk.sv
module dram_rc_seq_chk #(
  parameter int T_CAS = 2
) (
  input logic clk,
  input logic rst_n,
  input logic ras_n,
  input logic cas_n,
  input logic we_n,
  input logic oe,
  input logic done,
  input logic rd_valid
);

  logic [7:0] cas_lo_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cas_lo_cnt <= '0;
    else if (cas_n) cas_lo_cnt <= '0;
    else            cas_lo_cnt <= cas_lo_cnt + 8'd1;
  end

  // R4
  we_before_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cas_n) && !we_n) |-> $past(!we_n));

  // R4
  wb_cas_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ras_n) && !we_n) |-> !cas_n);

  // R4
  wb_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cas_n) && $past(ras_n)) |-> $rose(we_n));

  // R5
  oe_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe |-> !we_n);

  // R3
  cas_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cas_n) && !$past(ras_n)) |-> (cas_lo_cnt == 8'(T_CAS)));

  // R7
  read_cas_in_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cas_n && we_n) |-> !ras_n);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  rd_valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

endmodule

bind dram_rc_seq dram_rc_seq_chk #(.T_CAS(T_CAS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ras_n    (dram_ras_n),
  .cas_n    (dram_cas_n),
  .we_n     (dram_we_n),
  .oe       (dram_dq_oe),
  .done     (done),
  .rd_valid (rd_valid)
);

// File: tb/test_dram_rc_seq.sv
module test_dram_rc_seq;

  localparam int ROW_W = 6, COL_W = 6, DW = 1, MAX_BEATS = 4;
  localparam int T_RCD = 2, T_CAS = 2, T_RP = 2;
  localparam int AW = 6, BEAT_W = 2, NW = 1 << (ROW_W + COL_W);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, ref_grant = 1'b0;
  logic [ROW_W+COL_W-1:0] req_addr = '0;
  logic [BEAT_W-1:0] req_len = '0;
  logic [MAX_BEATS*DW-1:0] req_wdata = '0;
  logic [DW-1:0] rd_data, dram_dq_o, dram_dq_i;
  logic rd_valid, done, dram_ras_n, dram_cas_n, dram_we_n, dram_dq_oe;
  logic [AW-1:0] dram_addr;

  always #5 clk = ~clk;

  dram_rc_seq i_dram_rc_seq (.*);

  int tests = 0, fails = 0, cycles = 0;

  // behavioural DRAM and expected contents
  logic [NW*DW-1:0] mem_bits = '0;
  logic [NW*DW-1:0] exp_bits = '0;
  logic [ROW_W-1:0] row_l = '0;
  logic [COL_W-1:0] col_l = '0;
  assign dram_dq_i = (!dram_cas_n && dram_we_n) ? mem_bits[{row_l, col_l}*DW +: DW] : '0;

  // monitor state
  logic p_ras = 1'b1, p_cas = 1'b1, p_we = 1'b1;
  int ras_falls, ncas, nrd, ndone, since_ras, rcd_meas, cas_low, cas_bad, order_bad, oe_bad, dq_bad;
  logic [AW-1:0] row_seen;
  logic [AW-1:0] col_seen [MAX_BEATS];
  logic [DW-1:0] rd_seen [MAX_BEATS];
  logic [MAX_BEATS*DW-1:0] cur_wd;

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      since_ras++;
      if (p_ras && !dram_ras_n) begin
        ras_falls++; row_seen = dram_addr; row_l = dram_addr[ROW_W-1:0];
        since_ras = 0; rcd_meas = -1;
      end
      if (p_cas && !dram_cas_n) begin
        if (rcd_meas < 0) rcd_meas = since_ras;
        cas_low = 1;
        col_l = dram_addr[COL_W-1:0];
        if (ncas < MAX_BEATS) col_seen[ncas] = dram_addr;
        if (!dram_we_n) begin
          if (p_we) order_bad++;
          if (ncas < MAX_BEATS && dram_dq_o !== cur_wd[ncas*DW +: DW]) dq_bad++;
          mem_bits[{row_l, col_l}*DW +: DW] = dram_dq_o;
        end
        ncas++;
      end else if (!dram_cas_n) cas_low++;
      if (!p_cas && dram_cas_n) begin
        if (!p_ras && cas_low != T_CAS) cas_bad++;
        if (p_ras && !(dram_we_n && !p_we)) order_bad++;
      end
      if (!p_ras && dram_ras_n && !dram_we_n && dram_cas_n) order_bad++;
      if (dram_dq_oe && dram_we_n) oe_bad++;
      if (rd_valid && nrd < MAX_BEATS) begin rd_seen[nrd] = rd_data; nrd++; end
      if (done) ndone++;
    end
    p_ras = dram_ras_n; p_cas = dram_cas_n; p_we = dram_we_n;
  end

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(negedge clk) if (cycles >= 150000) begin
    fails++; $display("FAIL watchdog: run did not end"); summary();
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin fails++; $display("FAIL %s: actual %0d expected %0d", req, act, exp); end
  endtask

  function automatic int beat_idx(input int a, input int k);
    int row = a >> COL_W;
    int col = (a + k) & ((1 << COL_W) - 1);
    return (row << COL_W) | col;
  endfunction

  task automatic clr_mon();
    ras_falls = 0; ncas = 0; nrd = 0; ndone = 0; rcd_meas = -1; cas_bad = 0;
    order_bad = 0; oe_bad = 0; dq_bad = 0; since_ras = 0; cas_low = 0;
  endtask

  task automatic xact(input bit w, input int a, input int len,
                      input logic [MAX_BEATS*DW-1:0] wd, input bit scramble, input bit mid_grant);
    int guard = 0;
    bit scr = 0, pre_ok = 1;
    clr_mon();
    cur_wd = wd;
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a[ROW_W+COL_W-1:0];
    req_len = len[BEAT_W-1:0]; req_wdata = wd;
    while (!done && guard < 500) begin
      @(negedge clk);
      guard++;
      if (!dram_ras_n && !scr) begin
        scr = 1;
        if (scramble) begin req_addr = ~req_addr; req_write = ~w; req_wdata = ~wd; end
        if (mid_grant) ref_grant = 1'b1;
      end
    end
    req_valid = 1'b0;
    for (int i = 0; i < T_RP; i++) begin
      if (!(dram_ras_n && dram_cas_n && dram_we_n)) pre_ok = 0;
      @(negedge clk);
    end
    ref_grant = 1'b0;
    repeat (2) @(negedge clk);
    chk(ndone == 1, "R8 done count", ndone, 1);
    chk(pre_ok, "R8 precharge lines high", pre_ok, 1);
    chk(ras_falls == 1, "R7 single RAS fall", ras_falls, 1);
    chk(ncas == len + 1, "R7 CAS pulse count", ncas, len + 1);
    chk(row_seen == AW'(a >> COL_W), "R2 row address", row_seen, a >> COL_W);
    chk(rcd_meas == T_RCD + 1, "R3 RAS to CAS", rcd_meas, T_RCD + 1);
    chk(cas_bad == 0, "R3 CAS width", cas_bad, 0);
    for (int k = 0; k <= len && k < ncas; k++)
      chk(col_seen[k] == AW'(beat_idx(a, k) & ((1 << COL_W) - 1)), "R2 R7 column",
          col_seen[k], beat_idx(a, k) & ((1 << COL_W) - 1));
    if (w) begin
      chk(order_bad == 0, "R4 write order", order_bad, 0);
      chk(dq_bad == 0, "R5 write data at CAS", dq_bad, 0);
      for (int k = 0; k <= len; k++) begin
        int ix = beat_idx(a, k);
        exp_bits[ix*DW +: DW] = wd[k*DW +: DW];
        chk(mem_bits[ix*DW +: DW] == exp_bits[ix*DW +: DW], "R10 R5 stored word",
            mem_bits[ix*DW +: DW], exp_bits[ix*DW +: DW]);
      end
    end else begin
      chk(oe_bad == 0, "R5 no drive on read", oe_bad, 0);
      chk(nrd == len + 1, "R6 rd_valid count", nrd, len + 1);
      for (int k = 0; k <= len && k < nrd; k++) begin
        int ix = beat_idx(a, k);
        chk(rd_seen[k] == exp_bits[ix*DW +: DW], "R6 read data",
            rd_seen[k], exp_bits[ix*DW +: DW]);
      end
    end
  endtask

  initial begin
    void'($urandom(32'd20231));
    repeat (3) @(negedge clk);
    // R1 reset levels
    chk(dram_ras_n && dram_cas_n && dram_we_n && !dram_dq_oe && !done && !rd_valid,
        "R1 reset pins", {dram_ras_n, dram_cas_n, dram_we_n, dram_dq_oe}, 4'b1110);
    rst_n = 1'b1;
    @(negedge clk);
    chk(dram_ras_n && dram_cas_n && dram_we_n && !dram_dq_oe, "R1 after release",
        {dram_ras_n, dram_cas_n, dram_we_n, dram_dq_oe}, 4'b1110);

    // directed: row-end wrap burst write then read back
    xact(1, (5 << COL_W) | 62, 3, 4'b1011, 0, 0);
    xact(0, (5 << COL_W) | 62, 3, '0, 0, 0);
    xact(1, 0, 0, 4'b0001, 0, 0);
    xact(0, 0, 0, '0, 0, 0);

    // R9 grant held in idle blocks start
    clr_mon();
    ref_grant = 1'b1;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 12'h123; req_len = '0;
    repeat (20) @(negedge clk);
    chk(ras_falls == 0 && ndone == 0, "R9 blocked while granted", ras_falls + ndone, 0);
    req_valid = 1'b0;
    ref_grant = 1'b0;
    repeat (2) @(negedge clk);
    // R9 grant rising mid-access: access completes
    xact(1, 12'h2A7, 1, 4'b0010, 0, 1);
    // R10 fields changed after acceptance
    xact(1, 12'h3C5, 3, 4'b0110, 1, 0);
    xact(0, 12'h3C5, 3, '0, 1, 0);

    // random mix
    for (int n = 0; n < 60; n++) begin
      int a = $urandom % NW;
      int l = $urandom % MAX_BEATS;
      bit w = $urandom % 2;
      logic [MAX_BEATS*DW-1:0] wd = MAX_BEATS'($urandom);
      xact(w, a, l, wd, 0, 0);
    end
    summary();
  end

endmodule